// File: doc/BRIEF.md
# CEC Header Address Filter

This block sits behind the bit-level receiver of a consumer-electronics control bus. When the receiver reports that a header block has arrived, it compares the 4-bit destination with a programmable ownership mask. From that comparison it decides whether the frame is taken in, whether a positive acknowledge must be driven, and whether the rest of the frame is broadcast, owned, or skipped. While a broadcast frame is in progress, it also turns the receiver's bit-error strobes into Error-Bit requests, following a small set of policy flags.

The configuration word is loaded only while the block is disabled. Raising the enable freezes the configuration, and `cfg_locked_o` reports this. Line timing, bit sampling and signal-free time belong to the surrounding receiver.

The controller has five named states. **OFF** is the state while the enable is low. **WAIT_HDR** waits for a header. **BCAST** covers a broadcast frame, **DIRECT** an owned or listened frame, and **SKIP** an ignored frame. The transitions are:
- OFF→WAIT_HDR on an enabled clock.
- WAIT_HDR→BCAST on a header with destination 15.
- WAIT_HDR→DIRECT on any other accepted header.
- WAIT_HDR→SKIP on a rejected header.
- BCAST/DIRECT/SKIP→WAIT_HDR on `frame_end`.
- Any state→OFF when `en` is low.

Top module: `cec_hdr_filter`

## Requirements
- R1: After reset, every configuration field is zero, all three pulse outputs are low and `cfg_locked_o` is low.
- R2: On a clock edge with `en` low and `cfg_we` high, the configuration is loaded from `cfg_wdata`. The layout is: bit 19 listen, bits 18:4 ownership mask (bit 4+n owns address n), bit 3 broadcast-quiet, bit 2 stop-on-rising-error, bit 1 rising-error-gen-disable, bit 0 long-period-gen-disable.
- R3: A write presented while `en` is high is ignored and leaves the accept and acknowledge behaviour of later headers unchanged.
- R4: `cfg_locked_o` equals the value of `en` sampled at the previous clock edge.
- R5: A header in WAIT_HDR whose destination has its mask bit set gives a one-cycle `accept_o` and `ack_req_o` pulse one clock after `hdr_valid`. This holds for several owned addresses at once and in either listen setting.
- R6: A header with destination 15 is always accepted, whatever the mask and listen settings, and never raises `ack_req_o`.
- R7: With listen clear, a header whose destination is not owned raises neither output.
- R8: With listen set, a header whose destination is not owned raises `accept_o` without `ack_req_o`.
- R9: In BCAST, a rising error raises `errbit_req_o` one clock later only when stop-on-rising-error is 1, rising-error-gen-disable is 0 and broadcast-quiet is 0.
- R10: In BCAST, a long-period error raises `errbit_req_o` one clock later only when long-period-gen-disable is 0 and broadcast-quiet is 0.
- R11: In BCAST, a short-period error raises `errbit_req_o` one clock later unless both broadcast-quiet and listen are 1.
- R12: Error strobes outside BCAST never raise `errbit_req_o`.
- R13: Lowering `en` abandons any frame in progress. Headers and errors are ignored until `en` has been high for one clock, after which the next header is evaluated afresh.
- R14: A header is evaluated only in WAIT_HDR. A second `hdr_valid` before `frame_end` produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low allows configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 20 | Configuration word (layout in R2) |
| hdr_valid | input | 1 | Header block received strobe |
| hdr_dst | input | 4 | Destination address from the header |
| frame_end | input | 1 | End of current frame strobe |
| err_bre | input | 1 | Rising-edge bit error strobe |
| err_lbpe | input | 1 | Long bit period error strobe |
| err_sbpe | input | 1 | Short bit period error strobe |
| accept_o | output | 1 | Frame accepted pulse |
| ack_req_o | output | 1 | Drive acknowledge pulse |
| errbit_req_o | output | 1 | Drive Error-Bit pulse |
| cfg_locked_o | output | 1 | Configuration frozen flag |

## Verification
The bench first attempts a write while enabled whose new mask would take every address. A design that did not ignore that write would then accept a header that should be skipped.

It sends destination 15 under an empty mask and with listen both on and off. A design that indexed the mask with 15, or acknowledged broadcasts, shows an unexpected `ack_req_o`.

It walks the three error strobes through every combination of policy flags, including a short-period error with only one of quiet/listen set. It also repeats errors inside owned frames, which catches a policy applied outside broadcast.

Finally, it drops the enable in the middle of a frame and sends a second header without `frame_end`. These steps expose a controller that keeps stale state or evaluates headers twice.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;
    localparam int NUM_ADDR = 15;
    localparam int ADDR_W   = $clog2(NUM_ADDR + 1);
    localparam logic [ADDR_W-1:0] BCAST_ADDR = ADDR_W'(NUM_ADDR);

    typedef struct packed {
        logic                listen;
        logic [NUM_ADDR-1:0] own_mask;
        logic                bcast_quiet;
        logic                bre_stop;
        logic                bre_gen_off;
        logic                lbpe_gen_off;
    } cec_cfg_t;

    localparam int CFG_W = $bits(cec_cfg_t);

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT_HDR,
        ST_BCAST,
        ST_DIRECT,
        ST_SKIP
    } filt_state_e;
endpackage

// File: rtl/cec_cfg_reg.sv
module cec_cfg_reg
    import cec_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_allow,
    input  logic                 we,
    input  logic [CFG_W-1:0]     wdata,
    output cec_cfg_t             cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we && wr_allow) begin
            cfg_q <= cec_cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/cec_dest_match.sv
module cec_dest_match
    import cec_filt_pkg::*;
(
    input  cec_cfg_t             cfg,
    input  logic [ADDR_W-1:0]    dst,
    output logic                 is_bcast,
    output logic                 take,
    output logic                 give_ack
);
    logic [NUM_ADDR-1:0] hit_vec;
    logic                own_hit;

    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_addr
        assign hit_vec[i] = cfg.own_mask[i] && (dst == ADDR_W'(i));
    end

    assign own_hit  = |hit_vec;
    assign is_bcast = (dst == BCAST_ADDR);
    assign take     = is_bcast || own_hit || cfg.listen;
    assign give_ack = own_hit;
endmodule

// File: rtl/cec_berr_policy.sv
module cec_berr_policy
    import cec_filt_pkg::*;
(
    input  cec_cfg_t cfg,
    input  logic     bre,
    input  logic     lbpe,
    input  logic     sbpe,
    output logic     req
);
    logic bre_req, lbpe_req, sbpe_req;

    assign bre_req  = bre && cfg.bre_stop && !cfg.bre_gen_off && !cfg.bcast_quiet;
    assign lbpe_req = lbpe && !cfg.lbpe_gen_off && !cfg.bcast_quiet;
    assign sbpe_req = sbpe && !(cfg.bcast_quiet && cfg.listen);
    assign req      = bre_req || lbpe_req || sbpe_req;
endmodule

// File: rtl/cec_hdr_filter.sv
module cec_hdr_filter
    import cec_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 hdr_valid,
    input  logic [ADDR_W-1:0]    hdr_dst,
    input  logic                 frame_end,
    input  logic                 err_bre,
    input  logic                 err_lbpe,
    input  logic                 err_sbpe,
    output logic                 accept_o,
    output logic                 ack_req_o,
    output logic                 errbit_req_o,
    output logic                 cfg_locked_o
);
    cec_cfg_t    cfg_q;
    filt_state_e state, nxt;
    logic        m_bcast, m_take, m_ack, pol_req;
    logic        hdr_now;

    cec_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_allow (!en),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg_q    (cfg_q)
    );

    cec_dest_match u_match (
        .cfg      (cfg_q),
        .dst      (hdr_dst),
        .is_bcast (m_bcast),
        .take     (m_take),
        .give_ack (m_ack)
    );

    cec_berr_policy u_policy (
        .cfg  (cfg_q),
        .bre  (err_bre),
        .lbpe (err_lbpe),
        .sbpe (err_sbpe),
        .req  (pol_req)
    );

    assign hdr_now = en && (state == ST_WAIT_HDR) && hdr_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:      nxt = ST_WAIT_HDR;
            ST_WAIT_HDR: begin
                if (hdr_valid) begin
                    if (m_bcast)     nxt = ST_BCAST;
                    else if (m_take) nxt = ST_DIRECT;
                    else             nxt = ST_SKIP;
                end
            end
            ST_BCAST, ST_DIRECT, ST_SKIP: begin
                if (frame_end) nxt = ST_WAIT_HDR;
            end
            default:     nxt = ST_OFF;
        endcase
        if (!en) nxt = ST_OFF;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_o     <= 1'b0;
            ack_req_o    <= 1'b0;
            errbit_req_o <= 1'b0;
        end else begin
            accept_o     <= hdr_now && m_take;
            ack_req_o    <= hdr_now && m_ack;
            errbit_req_o <= en && (state == ST_BCAST) && pol_req;
        end
    end

    assign cfg_locked_o = (state != ST_OFF);
endmodule

// File: rtl/cec_hdr_filter_chk.sv
module cec_hdr_filter_chk
    import cec_filt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input cec_cfg_t          cfg_q,
    input logic              hdr_valid,
    input logic [ADDR_W-1:0] hdr_dst,
    input logic              err_bre,
    input logic              err_lbpe,
    input logic              err_sbpe,
    input logic              accept_o,
    input logic              ack_req_o,
    input logic              errbit_req_o,
    input logic              cfg_locked_o
);
    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !en) |=> (cfg_q == cec_cfg_t'($past(cfg_wdata))));

    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cfg_q));

    assert_locked_follows_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked_o |-> $past(en));

    assert_ack_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> accept_o);

    assert_bcast_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_dst == BCAST_ADDR) |=> !ack_req_o);

    assert_errbit_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        errbit_req_o |-> $past(err_bre || err_lbpe || err_sbpe));

    assert_off_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(accept_o || ack_req_o || errbit_req_o || cfg_locked_o));

    assert_accept_needs_hdr_R14: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(hdr_valid && en));
endmodule

bind cec_hdr_filter cec_hdr_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_q        (cfg_q),
    .hdr_valid    (hdr_valid),
    .hdr_dst      (hdr_dst),
    .err_bre      (err_bre),
    .err_lbpe     (err_lbpe),
    .err_sbpe     (err_sbpe),
    .accept_o     (accept_o),
    .ack_req_o    (ack_req_o),
    .errbit_req_o (errbit_req_o),
    .cfg_locked_o (cfg_locked_o)
);

// File: tb/cec_hdr_filter_tb.sv
`timescale 1ns/1ps
module cec_hdr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic        hdr_valid = 1'b0;
    logic [3:0]  hdr_dst = '0;
    logic        frame_end = 1'b0;
    logic        err_bre = 1'b0, err_lbpe = 1'b0, err_sbpe = 1'b0;
    logic        accept_o, ack_req_o, errbit_req_o, cfg_locked_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    cec_hdr_filter u_dut (
        .clk (clk), .rst_n (rst_n), .en (en), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .hdr_valid (hdr_valid), .hdr_dst (hdr_dst), .frame_end (frame_end),
        .err_bre (err_bre), .err_lbpe (err_lbpe), .err_sbpe (err_sbpe),
        .accept_o (accept_o), .ack_req_o (ack_req_o), .errbit_req_o (errbit_req_o),
        .cfg_locked_o (cfg_locked_o)
    );

    // behavioural reference: 0 off, 1 waiting, 2 broadcast, 3 taken, 4 skipped
    logic [19:0] m_cfg = '0;
    int          m_mode = 0;
    bit          e_acc = 0, e_ack = 0, e_err = 0, e_lock = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = '0; m_mode = 0; e_acc = 0; e_ack = 0; e_err = 0; e_lock = 0;
        end else begin
            bit lis, quiet, owned;
            lis = m_cfg[19]; quiet = m_cfg[3];
            e_acc = 0; e_ack = 0; e_err = 0;
            e_lock = en;
            if (!en) begin
                m_mode = 0;
            end else if (m_mode == 0) begin
                m_mode = 1;
            end else if (m_mode == 1) begin
                if (hdr_valid) begin
                    owned = (hdr_dst != 4'd15) && m_cfg[4 + hdr_dst];
                    if (hdr_dst == 4'd15) begin
                        e_acc = 1; m_mode = 2;
                    end else if (owned) begin
                        e_acc = 1; e_ack = 1; m_mode = 3;
                    end else if (lis) begin
                        e_acc = 1; m_mode = 3;
                    end else begin
                        m_mode = 4;
                    end
                end
            end else begin
                if (m_mode == 2) begin
                    if (err_bre && m_cfg[2] && !m_cfg[1] && !quiet) e_err = 1;
                    if (err_lbpe && !m_cfg[0] && !quiet) e_err = 1;
                    if (err_sbpe && !(quiet && lis)) e_err = 1;
                end
                if (frame_end) m_mode = 1;
            end
            if (cfg_we && !en) m_cfg = cfg_wdata;
        end
    end

    task automatic cmp(string name, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cmp("accept_o", accept_o, e_acc);
        cmp("ack_req_o", ack_req_o, e_ack);
        cmp("errbit_req_o", errbit_req_o, e_err);
        cmp("cfg_locked_o", cfg_locked_o, e_lock);
        cfg_we = 0; hdr_valid = 0; frame_end = 0;
        err_bre = 0; err_lbpe = 0; err_sbpe = 0;
    endtask

    function automatic logic [19:0] mk(bit lis, logic [14:0] mask, bit quiet,
                                       bit stop, bit bgen_off, bit lgen_off);
        return {lis, mask, quiet, stop, bgen_off, lgen_off};
    endfunction

    task automatic wr(logic [19:0] w);
        cfg_we = 1; cfg_wdata = w; cyc();
    endtask

    task automatic hdr(logic [3:0] d);
        hdr_valid = 1; hdr_dst = d; cyc(); cyc();
    endtask

    task automatic fend();
        frame_end = 1; cyc();
    endtask

    task automatic errs(bit b, bit l, bit s);
        err_bre = b; err_lbpe = l; err_sbpe = s; cyc(); cyc();
    endtask

    task automatic enable_on();
        en = 1; cyc(); cyc();
    endtask

    task automatic enable_off();
        en = 0; cyc(); cyc();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc(); cyc();

        cur_req = "R2";
        wr(mk(0, 15'b000_0000_0010_0001, 0, 1, 0, 0));
        cur_req = "R4";
        enable_on();
        cur_req = "R3";
        wr(mk(1, 15'h7FFF, 1, 0, 1, 1));
        cur_req = "R5";
        hdr(4'd5); fend();
        hdr(4'd0); errs(1, 1, 1); fend();
        cur_req = "R7";
        hdr(4'd3); fend();
        cur_req = "R6";
        hdr(4'd15);
        cur_req = "R9";  errs(1, 0, 0);
        cur_req = "R10"; errs(0, 1, 0);
        cur_req = "R11"; errs(0, 0, 1);
        cur_req = "R14"; hdr(4'd5); hdr(4'd15);
        fend();
        cur_req = "R12"; errs(1, 1, 1);

        cur_req = "R13";
        hdr(4'd15);
        en = 0; err_sbpe = 1; cyc();
        hdr_valid = 1; hdr_dst = 4'd5; cyc(); cyc();
        wr(mk(1, 15'h4000, 1, 1, 0, 0));
        en = 1; hdr_valid = 1; hdr_dst = 4'd14; cyc(); cyc();
        hdr(4'd14); fend();

        cur_req = "R8";
        hdr(4'd3); fend();
        cur_req = "R6";
        hdr(4'd15);
        cur_req = "R11"; errs(1, 1, 1);
        fend();

        enable_off();
        cur_req = "R11";
        wr(mk(0, 15'h0000, 1, 1, 0, 0));
        enable_on();
        hdr(4'd15); errs(0, 0, 1); errs(1, 1, 0); fend();
        cur_req = "R6"; hdr(4'd9); fend();

        enable_off();
        cur_req = "R9";
        wr(mk(0, 15'h0000, 0, 1, 1, 0));
        enable_on();
        hdr(4'd15); errs(1, 0, 0);
        cur_req = "R10"; errs(0, 1, 0);
        fend();
        enable_off();
        wr(mk(1, 15'h0000, 0, 0, 0, 1));
        enable_on();
        hdr(4'd15); errs(1, 1, 0);
        cur_req = "R11"; errs(0, 0, 1);
        fend();

        cur_req = "R5";
        enable_off();
        wr(mk(1, 15'b100_0000_1000_0010, 0, 1, 0, 0));
        enable_on();
        hdr(4'd1); fend(); hdr(4'd7); fend(); hdr(4'd14); fend(); hdr(4'd2); fend();

        cur_req = "R13";
        for (int i = 0; i < 2000; i++) begin
            if (($urandom % 40) == 0) en = ~en;
            cfg_we    = (($urandom % 16) == 0);
            cfg_wdata = 20'($urandom);
            hdr_valid = (($urandom % 4) == 0);
            hdr_dst   = 4'($urandom);
            frame_end = (($urandom % 6) == 0);
            err_bre   = (($urandom % 5) == 0);
            err_lbpe  = (($urandom % 5) == 0);
            err_sbpe  = (($urandom % 5) == 0);
            cyc();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule